// File: doc/BRIEF.md
# Latched Interrupt Status Controller

This block gathers the interrupt sources of a small 8-bit system and presents them to the processor as a single active-low, level-sensitive interrupt line. Software sees three byte-wide registers through a simple read/write port. The enable register picks which sources may reach the line and also carries a global gate. The status register reports which sources are pending. The acknowledge register is write-only: each 1 written to it clears a pending latched source.

The sources come in three kinds. Some are latched events: a keyboard column going low, a wake request on an address line, a battery-low warning, and the rising edge of the flap-open signal. Two are live grouped sources: the UART and the timer each reach the status register as the OR of their flags, each flag ANDed with its own mask bit. The last kind is the raw flap-open level, which software can read but which never raises the interrupt line. A separate active-low non-maskable output gives a one-cycle pulse for critical events such as power failure or card insertion. It ignores the enable register and needs no acknowledge.

Top module: `irq_aggregator`

## Requirements
- R1: After reset, the enable register reads 0x00, every latched status bit reads 0, `int_n` is 1 and `nmi_n` is 1.
- R2: The register addresses are: enable at 0 (read/write), status at 1 (read-only), acknowledge at 2 (write-only, reads 0x00). Address 3 reads 0x00. Writes to the status address have no effect.
- R3: The status bit positions are fixed as follows. Bit 7 is the live `flap_open` level. Bit 6 is the wake event. Bit 5 is the flap edge. Bit 4 is the UART. Bit 3 is battery-low. Bit 2 is the keyboard. Bit 1 always reads 0. Bit 0 is the timer.
- R4: Status bit 4 equals the OR over i of `uart_flags[i] & uart_mask[i]`. It follows the inputs combinationally and is not latched.
- R5: Status bit 0 equals the OR over i of `tmr_flags[i] & tmr_mask[i]`. It is not latched.
- R6: Status bit 5 sets on a rising edge of `flap_open`, stays set after the input falls, and clears when a 1 is written to acknowledge bit 5. A high `flap_open` level with no new edge does not set it again.
- R7: Status bits 6, 3 and 2 set while `wake_a19`, `batt_low` and `kbd_col_low` respectively are high. Each clears when a 1 is written to acknowledge bit 6, 3 or 2 respectively. Acknowledge bits 7, 4, 1 and 0 change nothing.
- R8: If a latched bit's set condition and its acknowledge happen in the same cycle, the bit stays set.
- R9: `int_n` is 0 exactly when enable bit 0 is 1 and at least one of the following pairs are both 1: (status bit 0, enable bit 1), or (status bit k, enable bit k) for k = 2 to 6.
- R10: When enable bit 0 is 0, `int_n` stays 1 whatever the status holds.
- R11: Status bit 7 and enable bit 7 never affect `int_n`. Enable bit 7 is stored and read back.
- R12: `int_n` is registered. It reflects the status and enable values present before the clock edge at which it changes. A latched source therefore reaches `int_n` two edges after its input rises.
- R13: Each rising edge of any `crit_evt` bit drives `nmi_n` low for exactly one cycle, one edge after the input rises, regardless of the enable register. A held-high input produces no further pulses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_addr | input | 2 | Register select (0 enable, 1 status, 2 acknowledge) |
| reg_we | input | 1 | Write strobe |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for `reg_addr`, combinational |
| flap_open | input | 1 | Flap-open level |
| batt_low | input | 1 | Battery-low level |
| kbd_col_low | input | 1 | Keyboard column-low event |
| wake_a19 | input | 1 | Address-line wake event |
| uart_flags | input | UART_W | UART sub-source flags |
| uart_mask | input | UART_W | UART flag masks |
| tmr_flags | input | TMR_W | Timer sub-source flags |
| tmr_mask | input | TMR_W | Timer flag masks |
| crit_evt | input | CRIT_W | Critical-event inputs for the non-maskable output |
| int_n | output | 1 | Registered active-low maskable interrupt |
| nmi_n | output | 1 | Active-low one-cycle non-maskable pulse |

## Verification
A wrongly held or wrongly cleared latch appears on the status read in the cycle after the edge that caused it. It also appears on `int_n` one edge after that, provided the matching enable bit and the global gate are set. The bench sweeps every enable value against every combination of six sources. Because of this, a bit misrouted between the status and enable layouts, a broken global gate, or a flap level leaking into the line shows up on `int_n` within two cycles of the write that exposes it. A non-maskable pulse that is too long, missing or repeated shows up on `nmi_n` in the cycle after the edge.

// File: rtl/irq_pkg.sv
package irq_pkg;

    localparam int DATA_W = 8;
    localparam int ADDR_W = 2;

    typedef enum logic [ADDR_W-1:0] {
        REG_ENABLE = 2'd0,
        REG_STATUS = 2'd1,
        REG_ACK    = 2'd2,
        REG_NONE   = 2'd3
    } reg_sel_e;

    // status bit positions
    localparam int ST_TMR  = 0;
    localparam int ST_KEY  = 2;
    localparam int ST_BATT = 3;
    localparam int ST_UART = 4;
    localparam int ST_FLAP = 5;
    localparam int ST_WAKE = 6;
    localparam int ST_LID  = 7;

    // enable bit positions
    localparam int EN_GATE = 0;
    localparam int EN_TMR  = 1;
    localparam int EN_KEY  = 2;
    localparam int EN_BATT = 3;
    localparam int EN_UART = 4;
    localparam int EN_FLAP = 5;
    localparam int EN_WAKE = 6;

    // latched-source slot order inside the aggregator
    localparam int LATCH_N  = 4;
    localparam int SLOT_KEY  = 0;
    localparam int SLOT_FLAP = 1;
    localparam int SLOT_BATT = 2;
    localparam int SLOT_WAKE = 3;

    typedef struct packed {
        logic [DATA_W-1:0] en;
        logic              int_n;
    } agg_state_t;

endpackage

// File: rtl/irq_latch_bit.sv
module irq_latch_bit #(
    parameter bit RISE_ONLY = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic src,
    input  logic clr,
    output logic flag
);
    logic set;
    logic flag_d, flag_q;

    generate
        if (RISE_ONLY) begin : g_edge
            logic prev_d, prev_q;
            always_comb begin
                prev_d = src;
                set    = src & ~prev_q;
            end
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) prev_q <= 1'b0;
                else        prev_q <= prev_d;
            end
        end else begin : g_level
            always_comb set = src;
        end
    endgenerate

    // a new set condition beats a clear in the same cycle
    always_comb flag_d = set | (flag_q & ~clr);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) flag_q <= 1'b0;
        else        flag_q <= flag_d;
    end

    assign flag = flag_q;
endmodule

// File: rtl/irq_masked_or.sv
module irq_masked_or #(
    parameter int W = 4
) (
    input  logic [W-1:0] flags,
    input  logic [W-1:0] mask,
    output logic         hit
);
    always_comb hit = |(flags & mask);
endmodule

// File: rtl/irq_nmi_gen.sv
module irq_nmi_gen #(
    parameter int N = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] evt,
    output logic         nmi_n
);
    typedef struct packed {
        logic [N-1:0] prev;
        logic         pulse_n;
    } nmi_state_t;

    nmi_state_t st_d, st_q;

    always_comb begin
        st_d.prev    = evt;
        st_d.pulse_n = ~|(evt & ~st_q.prev);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.prev    <= '0;
            st_q.pulse_n <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign nmi_n = st_q.pulse_n;
endmodule

// File: rtl/irq_aggregator.sv
module irq_aggregator
    import irq_pkg::*;
#(
    parameter int UART_W = 4,
    parameter int TMR_W  = 3,
    parameter int CRIT_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic              reg_we,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    input  logic              flap_open,
    input  logic              batt_low,
    input  logic              kbd_col_low,
    input  logic              wake_a19,
    input  logic [UART_W-1:0] uart_flags,
    input  logic [UART_W-1:0] uart_mask,
    input  logic [TMR_W-1:0]  tmr_flags,
    input  logic [TMR_W-1:0]  tmr_mask,
    input  logic [CRIT_W-1:0] crit_evt,
    output logic              int_n,
    output logic              nmi_n
);
    agg_state_t st_d, st_q;

    logic               en_wr, ack_wr;
    logic [LATCH_N-1:0] latch_src, latch_clr, latch_flag;
    logic               uart_hit, tmr_hit;
    logic [DATA_W-1:0]  status;
    logic [DATA_W-1:0]  gate_map;
    logic               irq_req;

    always_comb begin
        en_wr  = reg_we && (reg_addr == REG_ENABLE);
        ack_wr = reg_we && (reg_addr == REG_ACK);
    end

    // latched sources, slot order from the package
    always_comb begin
        latch_src[SLOT_KEY]  = kbd_col_low;
        latch_src[SLOT_FLAP] = flap_open;
        latch_src[SLOT_BATT] = batt_low;
        latch_src[SLOT_WAKE] = wake_a19;
        latch_clr[SLOT_KEY]  = ack_wr & reg_wdata[ST_KEY];
        latch_clr[SLOT_FLAP] = ack_wr & reg_wdata[ST_FLAP];
        latch_clr[SLOT_BATT] = ack_wr & reg_wdata[ST_BATT];
        latch_clr[SLOT_WAKE] = ack_wr & reg_wdata[ST_WAKE];
    end

    generate
        for (genvar g = 0; g < LATCH_N; g++) begin : g_latch
            irq_latch_bit #(
                .RISE_ONLY(g == SLOT_FLAP)
            ) u_lat (
                .clk  (clk),
                .rst_n(rst_n),
                .src  (latch_src[g]),
                .clr  (latch_clr[g]),
                .flag (latch_flag[g])
            );
        end
    endgenerate

    irq_masked_or #(.W(UART_W)) u_uart_or (
        .flags(uart_flags),
        .mask (uart_mask),
        .hit  (uart_hit)
    );

    irq_masked_or #(.W(TMR_W)) u_tmr_or (
        .flags(tmr_flags),
        .mask (tmr_mask),
        .hit  (tmr_hit)
    );

    irq_nmi_gen #(.N(CRIT_W)) u_nmi (
        .clk  (clk),
        .rst_n(rst_n),
        .evt  (crit_evt),
        .nmi_n(nmi_n)
    );

    // status assembly
    always_comb begin
        status          = '0;
        status[ST_LID]  = flap_open;
        status[ST_WAKE] = latch_flag[SLOT_WAKE];
        status[ST_FLAP] = latch_flag[SLOT_FLAP];
        status[ST_UART] = uart_hit;
        status[ST_BATT] = latch_flag[SLOT_BATT];
        status[ST_KEY]  = latch_flag[SLOT_KEY];
        status[ST_TMR]  = tmr_hit;
    end

    // enable bits moved onto status positions; the timer pair is offset
    always_comb begin
        gate_map          = '0;
        gate_map[ST_WAKE] = st_q.en[EN_WAKE];
        gate_map[ST_FLAP] = st_q.en[EN_FLAP];
        gate_map[ST_UART] = st_q.en[EN_UART];
        gate_map[ST_BATT] = st_q.en[EN_BATT];
        gate_map[ST_KEY]  = st_q.en[EN_KEY];
        gate_map[ST_TMR]  = st_q.en[EN_TMR];
        irq_req           = st_q.en[EN_GATE] & |(status & gate_map);
    end

    always_comb begin
        st_d       = st_q;
        if (en_wr) st_d.en = reg_wdata;
        st_d.int_n = ~irq_req;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.en    <= '0;
            st_q.int_n <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        unique case (reg_addr)
            REG_ENABLE: reg_rdata = st_q.en;
            REG_STATUS: reg_rdata = status;
            default:    reg_rdata = '0;
        endcase
    end

    assign int_n = st_q.int_n;
endmodule

// File: rtl/irq_aggregator_chk.sv
module irq_aggregator_chk
    import irq_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic [DATA_W-1:0] en_q,
    input logic [DATA_W-1:0] status,
    input logic              ack_wr,
    input logic [DATA_W-1:0] reg_wdata,
    input logic [ADDR_W-1:0] reg_addr,
    input logic [DATA_W-1:0] reg_rdata,
    input logic              flap_open,
    input logic              kbd_col_low,
    input logic              int_n,
    input logic              nmi_n
);
    // R3
    status_layout_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_addr == REG_STATUS) |-> (reg_rdata[1] == 1'b0 && reg_rdata[7] == flap_open));

    // R6
    flap_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flap_open) |=> status[ST_FLAP]);

    // R7
    key_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_wr && reg_wdata[ST_KEY] && !kbd_col_low) |=> !status[ST_KEY]);

    // R9
    uart_line_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (en_q[EN_GATE] && en_q[EN_UART] && status[ST_UART]) |=> !int_n);

    // R10
    gate_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !en_q[EN_GATE] |=> int_n);

    // R13
    nmi_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !nmi_n |=> nmi_n);
endmodule

bind irq_aggregator irq_aggregator_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .en_q       (st_q.en),
    .status     (status),
    .ack_wr     (ack_wr),
    .reg_wdata  (reg_wdata),
    .reg_addr   (reg_addr),
    .reg_rdata  (reg_rdata),
    .flap_open  (flap_open),
    .kbd_col_low(kbd_col_low),
    .int_n      (int_n),
    .nmi_n      (nmi_n)
);

// File: tb/sim_irq_aggregator.sv
module sim_irq_aggregator;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] reg_addr = 2'd0;
    logic       reg_we = 1'b0;
    logic [7:0] reg_wdata = 8'h00;
    logic [7:0] reg_rdata;
    logic       flap_open = 1'b0, batt_low = 1'b0, kbd_col_low = 1'b0, wake_a19 = 1'b0;
    logic [3:0] uart_flags = '0, uart_mask = '0;
    logic [2:0] tmr_flags = '0, tmr_mask = '0;
    logic [1:0] crit_evt = '0;
    logic       int_n, nmi_n;

    int total = 0;
    int fails = 0;

    always #2 clk = ~clk;

    irq_aggregator u0 (
        .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_we(reg_we),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .flap_open(flap_open),
        .batt_low(batt_low), .kbd_col_low(kbd_col_low), .wake_a19(wake_a19),
        .uart_flags(uart_flags), .uart_mask(uart_mask), .tmr_flags(tmr_flags),
        .tmr_mask(tmr_mask), .crit_evt(crit_evt), .int_n(int_n), .nmi_n(nmi_n)
    );

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        total++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        reg_addr = a; reg_wdata = d; reg_we = 1'b1;
        tick();
        reg_we = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [7:0] d);
        reg_addr = a;
        #0.5;
        d = reg_rdata;
    endtask

    initial begin
        #800000;
        fails++; total++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

    initial begin
        logic [7:0] v;
        repeat (3) tick();
        rst_n = 1'b1;
        tick();

        // R1 reset state
        rd(2'd0, v); chk("R1 enable", v, 8'h00);
        rd(2'd1, v); chk("R1 status", v, 8'h00);
        chk("R1 int_n", {7'd0, int_n}, 8'h01);
        chk("R1 nmi_n", {7'd0, nmi_n}, 8'h01);

        // R2 / R11 address map and enable storage
        wr(2'd0, 8'hA4);
        rd(2'd0, v); chk("R2 enable readback", v, 8'hA4);
        chk("R11 enable bit7 stored", {7'd0, v[7]}, 8'h01);
        rd(2'd2, v); chk("R2 ack reads zero", v, 8'h00);
        rd(2'd3, v); chk("R2 addr3 reads zero", v, 8'h00);
        wr(2'd1, 8'hFF);
        rd(2'd1, v); chk("R2 status write ignored", v, 8'h00);
        wr(2'd0, 8'h00);

        // R4 UART masked OR sweep
        for (int i = 0; i < 256; i++) begin
            uart_flags = i[3:0]; uart_mask = i[7:4];
            rd(2'd1, v);
            chk("R4 uart bit", {7'd0, v[4]}, {7'd0, |(i[3:0] & i[7:4])});
        end
        uart_flags = '0; uart_mask = '0;

        // R5 timer masked OR sweep
        for (int i = 0; i < 64; i++) begin
            tmr_flags = i[2:0]; tmr_mask = i[5:3];
            rd(2'd1, v);
            chk("R5 timer bit", {7'd0, v[0]}, {7'd0, |(i[2:0] & i[5:3])});
        end
        tmr_flags = '0; tmr_mask = '0;

        // R6 flap edge latch
        flap_open = 1'b1; tick();
        rd(2'd1, v); chk("R6 flap set", v, 8'hA0);
        flap_open = 1'b0; tick();
        rd(2'd1, v); chk("R6 flap held after fall", v, 8'h20);
        wr(2'd2, 8'h20);
        rd(2'd1, v); chk("R6 flap acked", v, 8'h00);

        // R7 latched events and ignored ack bits
        kbd_col_low = 1'b1; batt_low = 1'b1; wake_a19 = 1'b1; flap_open = 1'b1;
        tick();
        kbd_col_low = 1'b0; batt_low = 1'b0; wake_a19 = 1'b0;
        tick();
        rd(2'd1, v); chk("R7 all latched", v, 8'hEC);
        wr(2'd2, 8'h93);
        rd(2'd1, v); chk("R7 ignored ack bits", v, 8'hEC);
        wr(2'd2, 8'h04); rd(2'd1, v); chk("R7 ack key", v, 8'hE8);
        wr(2'd2, 8'h08); rd(2'd1, v); chk("R7 ack batt", v, 8'hE0);
        wr(2'd2, 8'h40); rd(2'd1, v); chk("R7 ack wake", v, 8'hA0);
        wr(2'd2, 8'h20); rd(2'd1, v); chk("R6 high level no reset", v, 8'h80);
        tick();
        rd(2'd1, v); chk("R6 no re-set without edge", v, 8'h80);

        // R8 set beats ack
        flap_open = 1'b0; tick();
        flap_open = 1'b1;
        wr(2'd2, 8'h20);
        rd(2'd1, v); chk("R8 flap edge wins", v, 8'hA0);
        batt_low = 1'b1; tick();
        wr(2'd2, 8'h08);
        rd(2'd1, v); chk("R8 held batt wins", v, 8'hA8);
        batt_low = 1'b0;
        wr(2'd2, 8'hFF);
        flap_open = 1'b0; tick();

        // R12 latency of int_n through a latched source
        wr(2'd0, 8'h05);
        tick();
        kbd_col_low = 1'b1; tick();
        kbd_col_low = 1'b0;
        chk("R12 first edge", {7'd0, int_n}, 8'h01);
        tick();
        chk("R12 second edge", {7'd0, int_n}, 8'h00);
        wr(2'd2, 8'h04);
        chk("R12 ack edge", {7'd0, int_n}, 8'h00);
        tick();
        chk("R12 released", {7'd0, int_n}, 8'h01);
        wr(2'd0, 8'h00);

        // R13 non-maskable pulse
        crit_evt = 2'b01; tick();
        chk("R13 pulse low", {7'd0, nmi_n}, 8'h00);
        tick();
        chk("R13 one cycle", {7'd0, nmi_n}, 8'h01);
        tick();
        chk("R13 held no repeat", {7'd0, nmi_n}, 8'h01);
        crit_evt = 2'b11; tick();
        chk("R13 second input", {7'd0, nmi_n}, 8'h00);
        tick();
        chk("R13 second ends", {7'd0, nmi_n}, 8'h01);
        crit_evt = 2'b00; tick();
        chk("R13 fall no pulse", {7'd0, nmi_n}, 8'h01);

        // R9 / R10 / R11 sweep: p bits = tmr,key,batt,uart,flap,wake
        uart_mask = 4'hF; tmr_mask = 3'h7;
        for (int p = 0; p < 64; p++) begin
            logic [7:0] sexp;
            flap_open = 1'b0; uart_flags = '0; tmr_flags = '0;
            tick();
            wr(2'd2, 8'hFF);
            kbd_col_low = p[1]; batt_low = p[2]; wake_a19 = p[5]; flap_open = 1'b1;
            tick();
            kbd_col_low = 1'b0; batt_low = 1'b0; wake_a19 = 1'b0;
            if (!p[4]) wr(2'd2, 8'h20);
            uart_flags = {3'b000, p[3]};
            tmr_flags = {2'b00, p[0]};
            sexp = {1'b1, p[5], p[4], p[3], p[2], p[1], 1'b0, p[0]};
            rd(2'd1, v); chk("R3 status layout", v, sexp);
            for (int e = 0; e < 256; e++) begin
                logic any;
                logic [7:0] ev;
                ev = e[7:0];
                any = (p[0] & ev[1]) | (p[1] & ev[2]) | (p[2] & ev[3]) |
                      (p[3] & ev[4]) | (p[4] & ev[5]) | (p[5] & ev[6]);
                wr(2'd0, ev);
                tick();
                if (!ev[0])
                    chk("R10 gate off", {7'd0, int_n}, 8'h01);
                else if (p == 0)
                    chk("R11 flap level ignored", {7'd0, int_n}, 8'h01);
                else
                    chk("R9 int line", {7'd0, int_n}, {7'd0, ~any});
            end
        end

        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end
endmodule